// File: doc/BRIEF.md
# Complementary Dual-Rail Inverse S-Box

This block is a one-byte combinational inverse substitution unit built as two datapaths side by side. The true rail takes a byte and produces the standard inverse S-box value of the block cipher. It first applies the inverse affine map and then takes the multiplicative inverse in GF(2^8). The inversion is done in the tower field GF((2^4)^2): a linear change of basis takes the byte into the tower field, the tower field does the arithmetic, and the inverse basis change brings the result back. The complement rail has the same gate structure, with every XOR replaced by XNOR and every AND replaced by OR. When it is fed the bitwise inverse of the true input, every net in it is the bitwise inverse of the matching true-rail net. The two rails together therefore always carry a Hamming weight of exactly half their width.

The block is meant to sit in a decryption datapath that runs its state twice, once as true data and once as complemented data, so that the data dependence of the power drawn by the substitution layer cancels between the rails. A parameter adds an output register stage on both rails. That stage resets synchronously to a complementary pair.

Top module: `inv_sbox_dual`

## Requirements
- R1: For every byte on `in_true`, `out_true` equals the standard inverse S-box value. That value is the inverse modulo x^8+x^4+x^3+x+1 of the inverse affine image, where the affine image has bit i = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8] ^ k[i] with k = 0x05, and a zero image maps to zero.
- R2: Whenever `in_comp` is the bitwise inverse of `in_true`, `out_comp` is the bitwise inverse of `out_true` in the same cycle, and the internal affine and inversion results of the two rails are complementary as well.
- R3: The input 0x63 on `in_true`, whose inverse affine image is zero, yields 0x00 on `out_true`.
- R4: The input 0x9C on `in_comp`, whose complemented affine image is 0xFF, yields 0xFF on `out_comp`.
- R5: With `REG_OUT` = 1, both outputs take the result for the inputs sampled at a rising clock edge right after that edge, and hold it until the next edge.
- R6: With `REG_OUT` = 1, while `rst` is high at a rising edge, the outputs become `out_true` = 0x00 and `out_comp` = 0xFF.
- R7: With `REG_OUT` = 0, both outputs follow the inputs in the same cycle, and `rst` has no effect on them.
- R8: The rails are independent. `out_comp` always equals the bitwise inverse of the inverse S-box value of the bitwise inverse of `in_comp`, whatever `in_true` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and for the checks |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| in_true | input | 8 | Byte for the true rail |
| in_comp | input | 8 | Byte for the complement rail, normally the inverse of `in_true` |
| out_true | output | 8 | Inverse S-box of `in_true` |
| out_comp | output | 8 | Complemented inverse S-box of the inverse of `in_comp` |

## Verification
The hardest case to reach is an input whose inverse affine image is zero. Only 0x63 on the true rail and 0x9C on the complement rail take the field inversion through its fixed point, where every tower-field product collapses to zero or all ones. The bench applies that pair on its own before sweeping all 256 complementary pairs through both a registered and an unregistered instance. It then drives the two rails with unrelated bytes, so that a complement rail that leans on true-rail signals shows up as a mismatch.

// File: rtl/dual_sbox_pkg.sv
package dual_sbox_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NIB_W  = BYTE_W / 2;
    localparam int unsigned PROD_W = 2 * NIB_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [BYTE_W-1:0][BYTE_W-1:0] mat8_t;

    // Tower-field element: high and low coefficient over GF(2^4).
    typedef struct packed {
        nib_t hi;
        nib_t lo;
    } tower_t;

    localparam byte_t AFF_CONST = 8'h05;
    localparam nib_t  LAMBDA    = 4'hE;

    // Basis change into the tower field; row i gives the input bits feeding output bit i.
    localparam mat8_t ISO_FWD = {8'hA0, 8'hAC, 8'hD2, 8'h70,
                                 8'h14, 8'h82, 8'h06, 8'h71};

    // Rail-selected primitives: XOR becomes XNOR and AND becomes OR on the twin.
    function automatic logic bx(input logic p, input logic q, input bit twin);
        return twin ? ~(p ^ q) : (p ^ q);
    endfunction

    function automatic logic ba(input logic p, input logic q, input bit twin);
        return twin ? (p | q) : (p & q);
    endfunction

    function automatic nib_t nib_x(input nib_t a, input nib_t b, input bit twin);
        nib_t r;
        for (int i = 0; i < NIB_W; i++) r[i] = bx(a[i], b[i], twin);
        return r;
    endfunction

    // GF(2^4) product modulo x^4+x+1.
    function automatic nib_t gf4_mul(input nib_t a, input nib_t b, input bit twin);
        logic [PROD_W-1:0] p;
        logic [PROD_W-1:0] seen;
        nib_t c;
        p    = '0;
        seen = '0;
        for (int i = 0; i < NIB_W; i++) begin
            for (int j = 0; j < NIB_W; j++) begin
                if (!seen[i+j]) begin
                    p[i+j]    = ba(a[i], b[j], twin);
                    seen[i+j] = 1'b1;
                end else begin
                    p[i+j] = bx(p[i+j], ba(a[i], b[j], twin), twin);
                end
            end
        end
        c[0] = bx(p[0], p[4], twin);
        c[1] = bx(bx(p[1], p[4], twin), p[5], twin);
        c[2] = bx(bx(p[2], p[5], twin), p[6], twin);
        c[3] = bx(p[3], p[6], twin);
        return c;
    endfunction

    // Squaring: two gates, two plain wires.
    function automatic nib_t gf4_sq(input nib_t a, input bit twin);
        nib_t c;
        c[0] = bx(a[0], a[2], twin);
        c[1] = a[2];
        c[2] = bx(a[1], a[3], twin);
        c[3] = a[3];
        return c;
    endfunction

    // Inverse as a^14 = a^2 * a^4 * a^8; zero (or all ones on the twin) is a fixed point.
    function automatic nib_t gf4_inv(input nib_t a, input bit twin);
        nib_t a2, a4, a8;
        a2 = gf4_sq(a, twin);
        a4 = gf4_sq(a2, twin);
        a8 = gf4_sq(a4, twin);
        return gf4_mul(gf4_mul(a2, a4, twin), a8, twin);
    endfunction

    // Linear map over GF(2) as gate chains; every row must select at least one bit.
    function automatic byte_t lin8(input mat8_t m, input byte_t v, input bit twin);
        byte_t r;
        logic  acc;
        bit    started;
        for (int i = 0; i < BYTE_W; i++) begin
            acc     = 1'b0;
            started = 1'b0;
            for (int j = 0; j < BYTE_W; j++) begin
                if (m[i][j]) begin
                    acc     = started ? bx(acc, v[j], twin) : v[j];
                    started = 1'b1;
                end
            end
            r[i] = acc;
        end
        return r;
    endfunction

    function automatic mat8_t aff_rows();
        mat8_t m;
        m = '0;
        for (int i = 0; i < BYTE_W; i++) begin
            m[i][(i + 2) % BYTE_W] = 1'b1;
            m[i][(i + 5) % BYTE_W] = 1'b1;
            m[i][(i + 7) % BYTE_W] = 1'b1;
        end
        return m;
    endfunction

    // Gauss-Jordan inversion over GF(2), evaluated at elaboration.
    function automatic mat8_t mat8_inv(input mat8_t m);
        mat8_t a, r;
        byte_t tmp;
        int    piv;
        a = m;
        for (int i = 0; i < BYTE_W; i++) r[i] = byte_t'(1) << i;
        for (int col = 0; col < BYTE_W; col++) begin
            piv = col;
            for (int k = BYTE_W - 1; k >= col; k--) if (a[k][col]) piv = k;
            tmp = a[col]; a[col] = a[piv]; a[piv] = tmp;
            tmp = r[col]; r[col] = r[piv]; r[piv] = tmp;
            for (int k = 0; k < BYTE_W; k++) begin
                if (k != col && a[k][col]) begin
                    a[k] = a[k] ^ a[col];
                    r[k] = r[k] ^ r[col];
                end
            end
        end
        return r;
    endfunction

    localparam mat8_t AFF_MAT = aff_rows();
    localparam mat8_t ISO_BWD = mat8_inv(ISO_FWD);

endpackage

// File: rtl/dsb_aff_inv.sv
module dsb_aff_inv
    import dual_sbox_pkg::*;
#(
    parameter bit TWIN = 1'b0
) (
    input  byte_t d,
    output byte_t q
);
    // The constant stays an XOR on both rails: ~v ^ k equals ~(v ^ k).
    assign q = lin8(AFF_MAT, d, TWIN) ^ AFF_CONST;
endmodule

// File: rtl/dsb_field_inv.sv
module dsb_field_inv
    import dual_sbox_pkg::*;
#(
    parameter bit TWIN = 1'b0
) (
    input  byte_t d,
    output byte_t q
);
    localparam nib_t LAM = TWIN ? ~LAMBDA : LAMBDA;

    tower_t t_in;
    tower_t t_out;
    nib_t   hl_sum;
    nib_t   hi_term;
    nib_t   lo_term;
    nib_t   norm;
    nib_t   norm_inv;

    assign t_in     = tower_t'(lin8(ISO_FWD, d, TWIN));
    assign hl_sum   = nib_x(t_in.hi, t_in.lo, TWIN);
    assign hi_term  = gf4_mul(gf4_sq(t_in.hi, TWIN), LAM, TWIN);
    assign lo_term  = gf4_mul(hl_sum, t_in.lo, TWIN);
    assign norm     = nib_x(hi_term, lo_term, TWIN);
    assign norm_inv = gf4_inv(norm, TWIN);
    assign t_out.hi = gf4_mul(norm_inv, t_in.hi, TWIN);
    assign t_out.lo = gf4_mul(norm_inv, hl_sum, TWIN);
    assign q        = lin8(ISO_BWD, byte_t'(t_out), TWIN);
endmodule

// File: rtl/dsb_path.sv
module dsb_path
    import dual_sbox_pkg::*;
#(
    parameter bit TWIN = 1'b0
) (
    input  byte_t d,
    output byte_t aff,
    output byte_t q
);
    dsb_aff_inv #(.TWIN(TWIN)) u_aff (
        .d (d),
        .q (aff)
    );

    dsb_field_inv #(.TWIN(TWIN)) u_inv (
        .d (aff),
        .q (q)
    );
endmodule

// File: rtl/inv_sbox_dual.sv
module inv_sbox_dual
    import dual_sbox_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] in_true,
    input  logic [7:0] in_comp,
    output logic [7:0] out_true,
    output logic [7:0] out_comp
);
    byte_t aff_t, aff_c;
    byte_t res_t, res_c;

    dsb_path #(.TWIN(1'b0)) u_true (
        .d   (in_true),
        .aff (aff_t),
        .q   (res_t)
    );

    dsb_path #(.TWIN(1'b1)) u_comp (
        .d   (in_comp),
        .aff (aff_c),
        .q   (res_c)
    );

    // R2: the two rails stay complementary stage by stage.
    assert_aff_balance_R2: assert property (@(posedge clk) disable iff (rst)
        (in_comp == ~in_true) |-> (aff_c == ~aff_t));
    assert_res_balance_R2: assert property (@(posedge clk) disable iff (rst)
        (in_comp == ~in_true) |-> (res_c == ~res_t));
    // R3 / R4: fixed points of the inversion stage on each rail.
    assert_zero_fix_R3: assert property (@(posedge clk) disable iff (rst)
        (aff_t == 8'h00) |-> (res_t == 8'h00));
    assert_ones_fix_R4: assert property (@(posedge clk) disable iff (rst)
        (aff_c == 8'hFF) |-> (res_c == 8'hFF));

    generate
        if (REG_OUT) begin : g_reg
            byte_t q_t, q_c;

            always_ff @(posedge clk) begin
                if (rst) begin
                    q_t <= 8'h00;
                    q_c <= 8'hFF;
                end else begin
                    q_t <= res_t;
                    q_c <= res_c;
                end
            end

            assign out_true = q_t;
            assign out_comp = q_c;

            assert_reset_pair_R6: assert property (@(posedge clk)
                rst |=> (out_true == 8'h00 && out_comp == 8'hFF));
            assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
                (in_true == 8'h63) |=> (out_true == 8'h00));
            assert_out_balance_R2: assert property (@(posedge clk) disable iff (rst)
                (in_comp == ~in_true) |=> (out_comp == ~out_true));
        end else begin : g_comb
            assign out_true = res_t;
            assign out_comp = res_c;
        end
    endgenerate
endmodule

// File: tb/inv_sbox_dual_bench.sv
module inv_sbox_dual_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_true = 8'h00;
    logic [7:0] in_comp = 8'hFF;
    logic [7:0] r_true, r_comp, c_true, c_comp;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] ref_tab [256];
    logic [7:0] exp_rt, exp_rc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    inv_sbox_dual #(.REG_OUT(1'b1)) u_inv_sbox_dual (
        .clk(clk), .rst(rst), .in_true(in_true), .in_comp(in_comp),
        .out_true(r_true), .out_comp(r_comp));

    inv_sbox_dual #(.REG_OUT(1'b0)) u_inv_sbox_dual_comb (
        .clk(clk), .rst(rst), .in_true(in_true), .in_comp(in_comp),
        .out_true(c_true), .out_comp(c_comp));

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] ginv(input logic [7:0] a);
        logic [7:0] r = 8'h01;
        if (a == 8'h00) return 8'h00;
        for (int i = 0; i < 254; i++) r = gmul(r, a);
        return r;
    endfunction

    function automatic logic [7:0] affine_back(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = b[(i + 2) % 8] ^ b[(i + 5) % 8] ^ b[(i + 7) % 8];
        return r ^ 8'h05;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, check both instances, wait one edge, check the registered one.
    task automatic step(input logic [7:0] t, input logic [7:0] c);
        logic [7:0] et = ref_tab[t];
        logic [7:0] ec = ~ref_tab[~c];
        string cr = (c == ~t) ? "R2 complement" : "R8 independent";
        in_true = t;
        in_comp = c;
        #1;
        chk("R5 hold true", r_true, exp_rt);
        chk("R5 hold comp", r_comp, exp_rc);
        chk("R7 comb true (R1)", c_true, et);
        chk({"R7 comb ", cr}, c_comp, ec);
        @(posedge clk);
        @(negedge clk);
        chk("R1 reg true (R5)", r_true, et);
        chk({"R5 reg ", cr}, r_comp, ec);
        exp_rt = et;
        exp_rc = ec;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] lfsr_a = 8'h5B;
        logic [7:0] lfsr_b = 8'hC4;
        for (int i = 0; i < 256; i++) ref_tab[i] = ginv(affine_back(8'(i)));
        // Spot checks of the bench model against well-known values (R1).
        chk("R1 model 00", ref_tab[8'h00], 8'h52);
        chk("R1 model 01", ref_tab[8'h01], 8'h09);
        chk("R1 model 63", ref_tab[8'h63], 8'h00);

        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R6 reset true", r_true, 8'h00);
        chk("R6 reset comp", r_comp, 8'hFF);
        chk("R7 comb under reset true", c_true, 8'h52);
        chk("R7 comb under reset comp", c_comp, 8'hAD);
        exp_rt = 8'h00;
        exp_rc = 8'hFF;
        rst = 1'b0;

        // Fixed point of the inversion stage on both rails.
        step(8'h63, 8'h9C);
        chk("R3 zero image", r_true, 8'h00);
        chk("R4 ones image", r_comp, 8'hFF);

        // Full complementary sweep.
        for (int v = 0; v < 256; v++) step(8'(v), ~8'(v));

        // Rails driven with unrelated bytes.
        for (int k = 0; k < 64; k++) begin
            lfsr_a = {lfsr_a[6:0], lfsr_a[7] ^ lfsr_a[5] ^ lfsr_a[4] ^ lfsr_a[3]};
            lfsr_b = {lfsr_b[6:0], lfsr_b[7] ^ lfsr_b[5] ^ lfsr_b[4] ^ lfsr_b[3]};
            step(lfsr_a, lfsr_b ^ 8'(k));
        end

        // Reset again mid-run.
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R6 reset again true", r_true, 8'h00);
        chk("R6 reset again comp", r_comp, 8'hFF);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule